// File: doc/BRIEF.md
# Memory Self-Test Sequencer with Pause-on-Error

This block runs a self-test pass over a programmable address window of a two-bank memory. It first sweeps the window writing a pattern derived from each address, then sweeps it again reading every word back and comparing it against the same pattern. In looping mode the pattern is inverted on every new pass. A miscompare records the failing address and the bit-level difference (syndrome), ORs the syndrome into a sticky per-bit log, and may raise a one-cycle system data-error pulse.

In pause-on-error mode the sequencer stops at the first reported miscompare and keeps the address counter frozen. Software inspects the logs and then writes a continue command. That command clears the failing-address and syndrome registers and resumes the sweep just past the failure. Reads are pipelined, so when the failing read hit bank 0 and a bank-1 read was already in flight behind it, that second read is dropped and never re-issued. A separate strobe clears the per-bit log. A refresh tick generator runs beside the sequencer, with a programmable rate.

Software reaches the block through a flat word-addressed register port. Register 0 is control, 1 and 2 are the low and high bounds of the window (low must not exceed high), 3 is the failing address, 4 is the syndrome, 5 is the per-bit log, and 6 is status (bits 1:0 state, bit 2 pattern inversion). Reads return the selected register one cycle after the address is presented.

Top module: `mst_poe_top`

## Requirements
- R1: After reset, control reads 0x1000_0100: rate code 01 in bits 29:28, data-error disable set in bit 8, and every other bit clear. Bits 27:9, 31:30 and 7:3 always read zero whatever is written. The window is low 0 and high all ones, and the state (0 idle, 1 running, 2 halted, 3 done) is idle.
- R2: Setting execute (control bit 0) from idle performs a write sweep and then a read sweep over exactly the addresses low..high. The pattern is the address zero-extended, XOR all ones when inversion is set, and it starts at inversion 0. A single pass on a fault-free memory ends in done with a zero syndrome, and the memory port stays idle while the state is done.
- R3: A reported miscompare loads the failing address and the syndrome (read data XOR pattern) and ORs the syndrome into the per-bit log. The log is cleared only by writing control bit 5. A new run from idle clears the failing address and syndrome.
- R4: With pause-on-error (control bit 1) set, the first reported miscompare moves the state to halted. While halted the address counter is frozen and, after the first halted cycle, no memory access is issued.
- R5: Continue (control bit 3, write-only, always reads 0) in the halted state, with pause-on-error and execute set, returns the state to running. It zeroes the failing address and syndrome, leaves the per-bit log intact, and resumes at the address after the failing one.
- R6: In pause-on-error mode, when the failing read was to bank 0 (address bit 0 clear) and the next address was already being read, that next read is discarded. The sweep resumes two addresses past the failure, so an error there is never reported.
- R7: Continue written in any other situation, including in the halted state with pause-on-error cleared, or in the done state, changes no state and no log.
- R8: The data-error output pulses for one cycle per reported miscompare. It stays low when disable (bit 8) is set and either pause-on-error or free-run (bit 2) is set. Outside those modes disable has no effect.
- R9: With free-run set, each completed pass starts a new one with the inversion toggled, and the state never reaches done. Miscompares are logged without stopping unless pause-on-error is also set.
- R10: Execute is cleared by writing it 0, by reset, or by writing the node-reset bit (control bit 4). Clearing it returns the state to idle.
- R11: The refresh output pulses once every BASE, BASE/2 or BASE/4 cycles for rate codes 00, 01 and 10. Code 11 produces no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_bank | output | 1 | Bank of the access (address bit 0) |
| mem_wdata | output | DW | Pattern written |
| mem_rdata | input | DW | Read data, valid the cycle after a read access |
| data_err | output | 1 | System data-error pulse |
| refresh | output | 1 | Refresh tick |
| state | output | 2 | Sequencer state |

## Verification
The functions that collide are the capture of a bank-0 miscompare and the arrival, one cycle later, of the bank-1 read already in flight behind it. Faults are placed on adjacent even/odd addresses, and the run is judged by the per-bit log, the data-error pulse count and the resume point after continue. The reverse order (odd failure, then an even fault) must halt twice. The window edge (a fault at the last even address with the odd one behind it) is also covered, and a sweep over every single-address fault in plain mode checks address and syndrome capture.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  typedef struct packed {
    logic       exec;
    logic       poe;
    logic       frun;
    logic       dis;
    logic [1:0] rate;
  } cfg_t;

  localparam int RX_CTRL  = 0;
  localparam int RX_LO    = 1;
  localparam int RX_HI    = 2;
  localparam int RX_FAIL  = 3;
  localparam int RX_SYN   = 4;
  localparam int RX_LOG   = 5;
  localparam int RX_STAT  = 6;

  localparam int CB_EXEC  = 0;
  localparam int CB_POE   = 1;
  localparam int CB_FRUN  = 2;
  localparam int CB_CONT  = 3;
  localparam int CB_NRST  = 4;
  localparam int CB_LCLR  = 5;
  localparam int CB_DIS   = 8;
  localparam int CB_RATE  = 28;
endpackage

// File: rtl/mst_regs.sv
module mst_regs
  import mst_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] fail_addr,
  input  logic [DW-1:0] syndrome,
  input  logic [DW-1:0] bitlog,
  input  st_e           st,
  input  logic          pass_inv,
  output cfg_t          cfg,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi,
  output logic          cont_p,
  output logic          lclr_p,
  output logic [31:0]   rdata
);
  logic ctrl_wr;
  logic [31:0] ctrl_img;

  assign ctrl_wr = we && (addr == 3'(RX_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '{exec: 1'b0, poe: 1'b0, frun: 1'b0, dis: 1'b1, rate: 2'b01};
      lo     <= '0;
      hi     <= '1;
      cont_p <= 1'b0;
      lclr_p <= 1'b0;
    end else begin
      cont_p <= ctrl_wr && wdata[CB_CONT];
      lclr_p <= ctrl_wr && wdata[CB_LCLR];
      if (ctrl_wr) begin
        cfg.exec <= wdata[CB_EXEC] && !wdata[CB_NRST];
        cfg.poe  <= wdata[CB_POE];
        cfg.frun <= wdata[CB_FRUN];
        cfg.dis  <= wdata[CB_DIS];
        cfg.rate <= wdata[CB_RATE+1:CB_RATE];
      end
      if (we && addr == 3'(RX_LO)) lo <= wdata[AW-1:0];
      if (we && addr == 3'(RX_HI)) hi <= wdata[AW-1:0];
    end
  end

  always_comb begin
    ctrl_img = '0;
    ctrl_img[CB_EXEC] = cfg.exec;
    ctrl_img[CB_POE]  = cfg.poe;
    ctrl_img[CB_FRUN] = cfg.frun;
    ctrl_img[CB_DIS]  = cfg.dis;
    ctrl_img[CB_RATE+1:CB_RATE] = cfg.rate;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        3'(RX_CTRL): rdata <= ctrl_img;
        3'(RX_LO):   rdata <= 32'(lo);
        3'(RX_HI):   rdata <= 32'(hi);
        3'(RX_FAIL): rdata <= 32'(fail_addr);
        3'(RX_SYN):  rdata <= 32'(syndrome);
        3'(RX_LOG):  rdata <= 32'(bitlog);
        3'(RX_STAT): rdata <= {29'd0, pass_inv, st};
        default:     rdata <= '0;
      endcase
    end
  end

  // R10: a node-reset write always drops execute
  p_nrst_clears_exec_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[CB_NRST]) |=> !cfg.exec);
endmodule

// File: rtl/mst_refresh.sv
module mst_refresh #(
  parameter int BASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CW = $clog2(BASE) + 1;
  localparam logic [CW-1:0] LIM1 = CW'(BASE - 1);
  localparam logic [CW-1:0] LIM2 = CW'(BASE / 2 - 1);
  localparam logic [CW-1:0] LIM4 = CW'(BASE / 4 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (rate)
      2'b00:   lim = LIM1;
      2'b01:   lim = LIM2;
      default: lim = LIM4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || rate == 2'b11) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R11: the reserved rate code keeps the tick quiet
  p_rsv_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (rate == 2'b11 && $past(rate) == 2'b11) |-> !tick);
endmodule

// File: rtl/mst_seq.sv
module mst_seq
  import mst_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          cont_p,
  input  logic          lclr_p,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          data_err,
  output st_e           st,
  output logic          pass_inv,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] syndrome,
  output logic [DW-1:0] bitlog
);
  logic [AW:0]   cur;
  logic          wr_phase;
  logic          issued_all;
  logic          p1_v, p2_v;
  logic [AW-1:0] p1_addr, p2_addr;
  logic [DW-1:0] dq;

  logic          run, miss, halt_now, drained, cont_go, keep, issue, suppress, skip;
  logic [DW-1:0] syn;
  logic [AW:0]   resume;
  logic [AW:0]   hi_x;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic inv);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = ((i < AW) ? a[i % AW] : 1'b0) ^ inv;
    return r;
  endfunction

  assign hi_x     = {1'b0, hi};
  assign run      = (st == ST_RUN) && cfg.exec;
  assign syn      = dq ^ pat(p2_addr, pass_inv);
  assign miss     = run && p2_v && (|syn);
  assign halt_now = miss && cfg.poe;
  assign keep     = run && !halt_now;
  assign drained  = !wr_phase && issued_all && !(mem_en && !mem_we) && !p1_v && !p2_v;
  assign cont_go  = cont_p && (st == ST_HALT) && cfg.poe && cfg.exec;
  assign issue    = keep && (wr_phase || !issued_all);
  assign suppress = cfg.dis && (cfg.poe || cfg.frun);
  assign skip     = !p2_addr[0] && p1_v;
  assign resume   = {1'b0, p2_addr} + (skip ? (AW+1)'(2) : (AW+1)'(1));

  // read pipeline and memory port registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      p1_v      <= 1'b0;
      p2_v      <= 1'b0;
      p1_addr   <= '0;
      p2_addr   <= '0;
      dq        <= '0;
    end else begin
      mem_en    <= issue;
      mem_we    <= wr_phase;
      mem_addr  <= cur[AW-1:0];
      mem_wdata <= pat(cur[AW-1:0], pass_inv);
      p1_v      <= mem_en && !mem_we && keep;
      p2_v      <= p1_v && keep;
      p1_addr   <= mem_addr;
      p2_addr   <= p1_addr;
      dq        <= mem_rdata;
    end
  end

  // error capture
  always_ff @(posedge clk) begin
    if (rst) begin
      fail_addr <= '0;
      syndrome  <= '0;
      bitlog    <= '0;
      data_err  <= 1'b0;
    end else begin
      data_err <= miss && !suppress;
      if (miss) begin
        fail_addr <= p2_addr;
        syndrome  <= syn;
        bitlog    <= (lclr_p ? '0 : bitlog) | syn;
      end else if (lclr_p) begin
        bitlog <= '0;
      end
      if (cont_go || (st == ST_IDLE && cfg.exec)) begin
        fail_addr <= '0;
        syndrome  <= '0;
      end
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= '0;
      wr_phase   <= 1'b0;
      issued_all <= 1'b0;
      pass_inv   <= 1'b0;
    end else if (!cfg.exec) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          st         <= ST_RUN;
          cur        <= {1'b0, lo};
          wr_phase   <= 1'b1;
          issued_all <= 1'b0;
          pass_inv   <= 1'b0;
        end
        ST_RUN: begin
          if (halt_now) begin
            st         <= ST_HALT;
            cur        <= resume;
            issued_all <= (resume > hi_x);
          end else if (drained) begin
            if (cfg.frun) begin
              pass_inv   <= !pass_inv;
              wr_phase   <= 1'b1;
              cur        <= {1'b0, lo};
              issued_all <= 1'b0;
            end else begin
              st <= ST_DONE;
            end
          end else if (wr_phase) begin
            if (cur == hi_x) begin
              wr_phase <= 1'b0;
              cur      <= {1'b0, lo};
            end else begin
              cur <= cur + 1'b1;
            end
          end else if (!issued_all) begin
            if (cur == hi_x) issued_all <= 1'b1;
            cur <= cur + 1'b1;
          end
        end
        ST_HALT: if (cont_go) st <= ST_RUN;
        default: st <= ST_DONE;
      endcase
    end
  end

  // R4: the address counter is frozen while halted
  p_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT && !cont_go && cfg.exec) |=> (st == ST_HALT && $stable(cur)));
  // R4: no memory traffic once the halt has settled
  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT && $past(st) == ST_HALT) |-> !mem_en);
  // R2: a finished single pass leaves the memory port idle
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |-> !mem_en);
  // R5: an accepted continue empties the address and syndrome registers
  p_cont_clear_r5: assert property (@(posedge clk) disable iff (rst)
    cont_go |=> (fail_addr == '0 && syndrome == '0));
  // R8: the disable bit silences the system error pulse in the looping modes
  p_suppress_r8: assert property (@(posedge clk) disable iff (rst)
    (suppress && $past(suppress)) |-> !data_err);
endmodule

// File: rtl/mst_poe_top.sv
module mst_poe_top
  import mst_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int BASE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_bank,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          data_err,
  output logic          refresh,
  output logic [1:0]    state
);
  cfg_t          cfg;
  logic [AW-1:0] lo, hi, fail_addr;
  logic [DW-1:0] syndrome, bitlog;
  logic          cont_p, lclr_p, pass_inv;
  st_e           st;

  mst_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .fail_addr(fail_addr), .syndrome(syndrome), .bitlog(bitlog), .st(st),
    .pass_inv(pass_inv), .cfg(cfg), .lo(lo), .hi(hi), .cont_p(cont_p),
    .lclr_p(lclr_p), .rdata(reg_rdata)
  );

  mst_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .lo(lo), .hi(hi), .cont_p(cont_p),
    .lclr_p(lclr_p), .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .data_err(data_err), .st(st),
    .pass_inv(pass_inv), .fail_addr(fail_addr), .syndrome(syndrome), .bitlog(bitlog)
  );

  mst_refresh #(.BASE(BASE)) u_ref (
    .clk(clk), .rst(rst), .rate(cfg.rate), .tick(refresh)
  );

  assign mem_bank = mem_addr[0];
  assign state    = st;
endmodule

// File: tb/mst_poe_top_test.sv
`timescale 1ns/1ps
module mst_poe_top_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_en, mem_we, mem_bank, data_err, refresh;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [DW-1:0] mem   [16];
  logic [DW-1:0] fault [16];
  logic [DW-1:0] rq = '0;
  int derr_cnt = 0, rd_cnt = 0, wr_cnt = 0, rd_out = 0, halt_en = 0, w0 = 0, w1 = 0;
  logic [1:0] prev_state = 2'd0;
  logic [AW-1:0] mon_lo = '0, mon_hi = '1;

  always #2 clk = ~clk;

  mst_poe_top #(.AW(AW), .DW(DW), .BASE(BASE)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_bank(mem_bank), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .data_err(data_err), .refresh(refresh), .state(state)
  );

  assign mem_rdata = rq;

  always @(posedge clk) begin
    cycles++;
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) rq <= mem[mem_addr] ^ fault[mem_addr];
    if (data_err) derr_cnt++;
    if (mem_en && !mem_we) begin
      rd_cnt++;
      if (mem_addr < mon_lo || mem_addr > mon_hi) rd_out++;
    end
    if (mem_en && mem_we) begin
      wr_cnt++;
      if (mem_addr == mon_lo) begin
        if (mem_wdata == DW'(mon_lo)) w0++;
        else if (mem_wdata == (8'hFF ^ DW'(mon_lo))) w1++;
      end
    end
    if (state == 2'd2 && prev_state == 2'd2 && mem_en) halt_en++;
    prev_state <= state;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cw(input bit ex, input bit poe, input bit fr, input bit cont,
                                     input bit nr, input bit lc, input bit dis, input logic [1:0] rate);
    logic [31:0] w = '0;
    w[0] = ex; w[1] = poe; w[2] = fr; w[3] = cont; w[4] = nr; w[5] = lc; w[8] = dis;
    w[29:28] = rate;
    return w;
  endfunction

  task automatic wait_state(input logic [1:0] s);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (state == s) return;
    end
  endtask

  task automatic clr_mon();
    derr_cnt = 0; rd_cnt = 0; wr_cnt = 0; rd_out = 0; halt_en = 0; w0 = 0; w1 = 0;
  endtask

  task automatic clr_faults();
    for (int i = 0; i < 16; i++) fault[i] = '0;
  endtask

  task automatic start(input bit poe, input bit fr, input bit dis);
    wr(0, cw(0, poe, fr, 0, 0, 1, dis, 2'b01));
    clr_mon();
    wr(0, cw(1, poe, fr, 0, 0, 0, dis, 2'b01));
  endtask

  task automatic period(input logic [1:0] rate, output int p);
    p = 0;
    wr(0, cw(0, 0, 0, 0, 0, 0, 1, rate));
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (refresh) break;
      end
    end
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      if (refresh) begin p = i; break; end
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, f, s, l;
    int p;
    clr_faults();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, v); chk(v == 32'h1000_0100, "R1 ctrl reset", v, 32'h1000_0100);
    rd(2, v); chk(v == 32'hF, "R1 hi reset", v, 32'hF);
    chk(state == 2'd0, "R1 idle", state, 0);
    // R1 reserved bits read zero, write-only bits read zero
    wr(0, 32'h0FFF_FE00 | 32'h0000_00E0 | cw(0, 0, 0, 0, 0, 0, 1, 2'b01));
    rd(0, v); chk(v == 32'h1000_0100, "R1 reserved", v, 32'h1000_0100);

    // R2 window 4..9, clean memory
    mon_lo = 4'd4; mon_hi = 4'd9;
    wr(1, 4); wr(2, 9);
    start(0, 0, 1);
    wait_state(2'd3);
    chk(state == 2'd3, "R2 done", state, 3);
    chk(rd_cnt == 6 && wr_cnt == 6, "R2 access count", rd_cnt * 100 + wr_cnt, 606);
    chk(rd_out == 0, "R2 in window", rd_out, 0);
    rd(4, v); chk(v == 0, "R2 clean syndrome", v, 0);
    mon_lo = 4'd0; mon_hi = 4'hF;
    wr(1, 0); wr(2, 15);

    // R3 / R8 sweep every single-address fault in plain mode
    for (int a = 0; a < 16; a++) begin
      clr_faults();
      fault[a] = 8'(1 << (a % 8));
      start(0, 0, 1);
      wait_state(2'd3);
      rd(3, f); rd(4, s); rd(5, l);
      chk(f == 32'(a), "R3 fail addr", f, a);
      chk(s == 32'(fault[a]) && l == 32'(fault[a]), "R3 syndrome/log", {s[15:0], l[15:0]}, {16'(fault[a]), 16'(fault[a])});
      chk(derr_cnt == 1, "R8 plain pulse", derr_cnt, 1);
    end

    // R7 continue in done state, non-poe: ignored
    wr(0, cw(1, 0, 0, 1, 0, 0, 1, 2'b01));
    repeat (4) @(negedge clk);
    rd(3, f);
    chk(state == 2'd3 && f == 32'd15, "R7 done ignore", {state, f[7:0]}, {2'd3, 8'd15});

    // R4 R5 R6: bank0 failure at 6 hides the bank1 error at 7
    clr_faults();
    fault[6] = 8'h01; fault[7] = 8'h80;
    start(1, 0, 0);
    wait_state(2'd2);
    rd(3, f); rd(4, s);
    chk(f == 6 && s == 1, "R4 halt capture", {f[7:0], s[7:0]}, 16'h0601);
    repeat (20) @(negedge clk);
    chk(state == 2'd2 && halt_en == 0, "R4 held", halt_en, 0);
    chk(derr_cnt == 1, "R8 poe pulse", derr_cnt, 1);
    wr(0, cw(1, 1, 0, 1, 0, 0, 0, 2'b01));
    wait_state(2'd3);
    rd(3, f); rd(4, s); rd(5, l);
    chk(f == 0 && s == 0, "R5 cleared", {f[7:0], s[7:0]}, 0);
    chk(l == 32'h01, "R6 log skips bank1", l, 1);
    chk(derr_cnt == 1, "R6 no second report", derr_cnt, 1);
    rd(0, v); chk(v[3] == 1'b0, "R5 continue reads 0", v[3], 0);
    wr(0, cw(1, 1, 0, 0, 0, 1, 0, 2'b01));
    rd(5, l); chk(l == 0, "R3 log clear", l, 0);

    // R5 bank1 failure then bank0 failure: two halts
    clr_faults();
    fault[9] = 8'h02; fault[10] = 8'h04;
    start(1, 0, 0);
    wait_state(2'd2);
    rd(3, f); chk(f == 9, "R5 first halt", f, 9);
    // R7 continue with pause-on-error cleared is ignored
    wr(0, cw(1, 0, 0, 1, 0, 0, 0, 2'b01));
    repeat (6) @(negedge clk);
    rd(3, f); chk(state == 2'd2 && f == 9, "R7 halt ignore", {state, f[7:0]}, {2'd2, 8'd9});
    wr(0, cw(1, 1, 0, 1, 0, 0, 0, 2'b01));
    repeat (3) @(negedge clk);
    wait_state(2'd2);
    rd(3, f); rd(4, s); chk(f == 10 && s == 4, "R5 resume next", {f[7:0], s[7:0]}, 16'h0A04);
    wr(0, cw(1, 1, 0, 1, 0, 0, 0, 2'b01));
    wait_state(2'd3);
    rd(5, l); chk(l == 32'h06 && derr_cnt == 2, "R5 log kept", {l[7:0], 8'(derr_cnt)}, 16'h0602);

    // R6 window edge: 14 fails with 15 behind it
    clr_faults();
    fault[14] = 8'h10; fault[15] = 8'h20;
    start(1, 0, 1);
    wait_state(2'd2);
    chk(derr_cnt == 0, "R8 poe disabled", derr_cnt, 0);
    wr(0, cw(1, 1, 0, 1, 0, 0, 1, 2'b01));
    wait_state(2'd3);
    rd(5, l); chk(state == 2'd3 && l == 32'h10, "R6 edge", l, 32'h10);

    // R10 software clear from halt
    clr_faults(); fault[3] = 8'h08;
    start(1, 0, 1);
    wait_state(2'd2);
    wr(0, cw(0, 1, 0, 0, 0, 0, 1, 2'b01));
    @(negedge clk);
    chk(state == 2'd0, "R10 sw clear", state, 0);

    // R9 free-run clean: loops with inversion
    clr_faults();
    start(0, 1, 1);
    repeat (300) @(negedge clk);
    rd(5, l);
    chk(state == 2'd1, "R9 still running", state, 1);
    chk(w0 > 0 && w1 > 0, "R9 inversion", {w0, w1}, 1);
    chk(l == 0, "R9 no false error", l, 0);
    // R10 node reset while running
    wr(0, cw(1, 0, 1, 0, 1, 0, 1, 2'b01));
    @(negedge clk);
    rd(0, v);
    chk(state == 2'd0 && v[0] == 1'b0, "R10 node reset", {state, v[0]}, 0);

    // R9 R8 free-run with faults
    fault[5] = 8'h40;
    start(0, 1, 1);
    repeat (200) @(negedge clk);
    rd(5, l);
    chk(state == 2'd1 && l == 32'h40, "R9 logs and loops", l, 32'h40);
    chk(derr_cnt == 0, "R8 frun disabled", derr_cnt, 0);
    start(0, 1, 0);
    repeat (200) @(negedge clk);
    chk(derr_cnt > 1, "R8 frun enabled", derr_cnt, 2);
    wr(0, cw(0, 0, 0, 0, 0, 0, 1, 2'b01));

    // R11 refresh rates
    period(2'b00, p); chk(p == BASE, "R11 1x", p, BASE);
    period(2'b01, p); chk(p == BASE / 2, "R11 2x", p, BASE / 2);
    period(2'b10, p); chk(p == BASE / 4, "R11 4x", p, BASE / 4);
    wr(0, cw(0, 0, 0, 0, 0, 0, 1, 2'b11));
    p = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (refresh && i > 2) p++;
    end
    chk(p == 0, "R11 reserved", p, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule